// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts branches for an instruction pipeline. Each instruction address seen by decode is presented to a lookup port. If a matching entry is held, the block returns the stored target address and a direction taken from that entry's 2-bit history counter, so fetch can be steered early. A miss counts as a not-taken prediction.

A second port is driven from the last pipeline stage. For each branch it carries the real direction, the real target, and the prediction that was made for it. History counters change only here. A new entry is created only for a taken branch that is not already present. When the real outcome does not match the prediction, the block raises a one-cycle flush request together with the address from which fetch must restart.

The storage holds 64 sets of four ways. Within a set, empty ways are filled first. After that, a 3-bit tree pseudo-LRU chooses which way to replace.

Top module: `btb_top`

## Requirements
- R1: The set index is pc[7:2] and the tag is pc[31:8]. Up to four branches with the same index and different tags are held at the same time without disturbing one another.
- R2: When lk_req is high and a valid entry in set pc[7:2] matches the tag, lk_hit is 1 in the same cycle and lk_target is that entry's target. lk_taken is 1 exactly when the entry's counter is 2 or 3. At most one way matches.
- R3: When no entry matches, or lk_req is low, lk_hit and lk_taken are 0 and lk_target is 0.
- R4: A resolved taken branch that misses is given a new entry with counter 3 and the resolved target. A resolved not-taken branch that misses creates no entry.
- R5: A resolved branch that hits moves its counter up by one if taken, saturating at 3, or down by one if not taken, saturating at 0. A taken hit also overwrites the stored target with the resolved target.
- R6: One cycle after a resolve, flush is 1 exactly when the real direction differs from rs_pred_taken, or when both are taken and rs_target differs from rs_pred_target. flush_pc is then rs_target if the branch was taken, otherwise rs_pc+4. In all other cycles flush is 0.
- R7: Allocation uses the lowest-numbered invalid way of the set. If all four ways are valid, it uses the pseudo-LRU victim. The tree bit b0 selects the pair: 0 means ways 0/1 and 1 means ways 2/3. Bit b1 then picks way 0 (0) or way 1 (1), and bit b2 picks way 2 (0) or way 3 (1). Every resolve hit or allocation marks its way as most recently used.
- R8: A lookup in the same cycle as a resolve update to the same entry sees the state from before the update. The update is visible from the next cycle on.
- R9: Synchronous active-high reset invalidates every entry, clears all pseudo-LRU state and drives flush low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request from decode |
| lk_pc | input | 32 | Address of the instruction being decoded |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Predicted target (0 on a miss) |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_taken | input | 1 | Real direction |
| rs_target | input | 32 | Real target |
| rs_pred_taken | input | 1 | Direction that was predicted for this branch |
| rs_pred_target | input | 32 | Target that was predicted for this branch |
| flush | output | 1 | Misprediction: flush and restart |
| flush_pc | output | 32 | Restart address, valid while flush is 1 |

## Verification
A lookup and a resolve update can hit the same entry in the same cycle. In that cycle the lookup must return the old target and direction, while the flush and the new contents belong to the following cycle. The bench sets this up by presenting a lookup and a resolve of the same branch together, with a changed target. It then compares lk_target before and after the clock edge, and checks that the misprediction flush appears once, carrying the new target.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int ADDR_W     = 32;
    localparam int OFF_W      = 2;
    localparam int IDX_W      = 6;
    localparam int SETS       = 1 << IDX_W;
    localparam int WAYS       = 4;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int INSN_BYTES = 4;
    localparam int CTR_W      = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [CTR_W-1:0]  ctr_t;
    typedef logic [WAYS-2:0]   plru_t;

    localparam ctr_t CTR_MAX = '1;

    typedef struct packed {
        logic  hit;
        way_t  way;
        ctr_t  ctr;
        addr_t target;
    } probe_t;

    typedef struct packed {
        logic  en;
        logic  alloc;
        idx_t  idx;
        way_t  way;
        tag_t  tag;
        ctr_t  ctr;
        logic  wr_tgt;
        addr_t target;
    } wr_t;

    function automatic idx_t idx_of(addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic ctr_t ctr_next(ctr_t c, logic taken);
        if (taken) return (c == CTR_MAX) ? c : c + ctr_t'(1);
        return (c == '0) ? c : c - ctr_t'(1);
    endfunction

    function automatic way_t plru_victim(plru_t s);
        if (s[0]) return s[2] ? way_t'(3) : way_t'(2);
        return s[1] ? way_t'(1) : way_t'(0);
    endfunction

    function automatic plru_t plru_touch(plru_t s, way_t w);
        plru_t r = s;
        case (w)
            way_t'(0): begin r[0] = 1'b1; r[1] = 1'b1; end
            way_t'(1): begin r[0] = 1'b1; r[1] = 1'b0; end
            way_t'(2): begin r[0] = 1'b0; r[2] = 1'b1; end
            default:   begin r[0] = 1'b0; r[2] = 1'b0; end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  idx_t             lk_idx,
    input  tag_t             lk_tag,
    output probe_t           lk_res,
    input  idx_t             rs_idx,
    input  tag_t             rs_tag,
    output probe_t           rs_res,
    output logic [WAYS-1:0]  rs_vmask,
    input  wr_t              wr
);
    logic [WAYS-1:0] vld_q [SETS];
    tag_t            tag_q [SETS][WAYS];
    addr_t           tgt_q [SETS][WAYS];
    ctr_t            ctr_q [SETS][WAYS];

    logic [WAYS-1:0] lk_hv, rs_hv;

    function automatic logic [WAYS-1:0] match_vec(idx_t i, tag_t t);
        logic [WAYS-1:0] v = '0;
        for (int w = 0; w < WAYS; w++)
            v[w] = vld_q[i][w] && (tag_q[i][w] == t);
        return v;
    endfunction

    function automatic probe_t pick(idx_t i, logic [WAYS-1:0] hv);
        probe_t r = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hv[w]) begin
                r.hit    = 1'b1;
                r.way    = way_t'(w);
                r.ctr    = ctr_q[i][w];
                r.target = tgt_q[i][w];
            end
        end
        return r;
    endfunction

    assign lk_hv    = match_vec(lk_idx, lk_tag);
    assign rs_hv    = match_vec(rs_idx, rs_tag);
    assign lk_res   = pick(lk_idx, lk_hv);
    assign rs_res   = pick(rs_idx, rs_hv);
    assign rs_vmask = vld_q[rs_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (wr.en && wr.alloc) begin
            vld_q[wr.idx][wr.way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr.en) begin
            if (wr.alloc) tag_q[wr.idx][wr.way] <= wr.tag;
            ctr_q[wr.idx][wr.way] <= wr.ctr;
            if (wr.wr_tgt) tgt_q[wr.idx][wr.way] <= wr.target;
        end
    end

    // R2
    lk_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hv));

    // R4
    alloc_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.alloc) |=>
            (vld_q[$past(wr.idx)][$past(wr.way)] &&
             ctr_q[$past(wr.idx)][$past(wr.way)] == CTR_MAX));
endmodule

// File: rtl/btb_plru.sv
module btb_plru
    import btb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx,
    output way_t victim,
    input  logic touch_en,
    input  idx_t touch_idx,
    input  way_t touch_way
);
    plru_t tree_q [SETS];

    assign victim = plru_victim(tree_q[rd_idx]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_idx] <= plru_touch(tree_q[touch_idx], touch_way);
        end
    end

    // R7
    mru_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (plru_victim(tree_q[$past(touch_idx)]) != $past(touch_way)));
endmodule

// File: rtl/btb_judge.sv
module btb_judge
    import btb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rs_valid,
    input  addr_t rs_pc,
    input  logic  rs_taken,
    input  addr_t rs_target,
    input  logic  pred_taken,
    input  addr_t pred_target,
    output logic  flush,
    output addr_t flush_pc
);
    logic  wrong;
    addr_t fix_pc;

    always_comb begin
        wrong  = rs_valid && ((rs_taken != pred_taken) ||
                              (rs_taken && (rs_target != pred_target)));
        fix_pc = rs_taken ? rs_target : rs_pc + addr_t'(INSN_BYTES);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush    <= 1'b0;
            flush_pc <= '0;
        end else begin
            flush <= wrong;
            if (wrong) flush_pc <= fix_pc;
        end
    end

    // R6
    flush_needs_resolve_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> $past(rs_valid));
endmodule

// File: rtl/btb_top.sv
module btb_top
    import btb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_req,
    input  logic [31:0] lk_pc,
    output logic        lk_hit,
    output logic        lk_taken,
    output logic [31:0] lk_target,
    input  logic        rs_valid,
    input  logic [31:0] rs_pc,
    input  logic        rs_taken,
    input  logic [31:0] rs_target,
    input  logic        rs_pred_taken,
    input  logic [31:0] rs_pred_target,
    output logic        flush,
    output logic [31:0] flush_pc
);
    probe_t          lk_res, rs_res;
    logic [WAYS-1:0] rs_vmask;
    way_t            plru_way, free_way, alloc_way;
    logic            have_free;
    wr_t             wr;

    btb_store u_store (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (idx_of(lk_pc)),
        .lk_tag   (tag_of(lk_pc)),
        .lk_res   (lk_res),
        .rs_idx   (idx_of(rs_pc)),
        .rs_tag   (tag_of(rs_pc)),
        .rs_res   (rs_res),
        .rs_vmask (rs_vmask),
        .wr       (wr)
    );

    btb_plru u_plru (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (idx_of(rs_pc)),
        .victim    (plru_way),
        .touch_en  (wr.en),
        .touch_idx (wr.idx),
        .touch_way (wr.way)
    );

    btb_judge u_judge (
        .clk         (clk),
        .rst         (rst),
        .rs_valid    (rs_valid),
        .rs_pc       (rs_pc),
        .rs_taken    (rs_taken),
        .rs_target   (rs_target),
        .pred_taken  (rs_pred_taken),
        .pred_target (rs_pred_target),
        .flush       (flush),
        .flush_pc    (flush_pc)
    );

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!rs_vmask[w]) begin
                have_free = 1'b1;
                free_way  = way_t'(w);
            end
        end
        alloc_way = have_free ? free_way : plru_way;
    end

    always_comb begin
        wr        = '0;
        wr.en     = rs_valid && (rs_res.hit || rs_taken);
        wr.alloc  = !rs_res.hit;
        wr.idx    = idx_of(rs_pc);
        wr.tag    = tag_of(rs_pc);
        wr.way    = rs_res.hit ? rs_res.way : alloc_way;
        wr.ctr    = rs_res.hit ? ctr_next(rs_res.ctr, rs_taken) : CTR_MAX;
        wr.wr_tgt = rs_taken;
        wr.target = rs_target;
    end

    always_comb begin
        lk_hit    = lk_req && lk_res.hit;
        lk_taken  = lk_hit && lk_res.ctr[CTR_W-1];
        lk_target = lk_hit ? lk_res.target : '0;
    end
endmodule

// File: tb/sim_btb_top.sv
`timescale 1ns/1ps
module sim_btb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req;
    logic [31:0] lk_pc;
    logic        lk_hit, lk_taken;
    logic [31:0] lk_target;
    logic        rs_valid, rs_taken, rs_pred_taken;
    logic [31:0] rs_pc, rs_target, rs_pred_target;
    logic        flush;
    logic [31:0] flush_pc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    btb_top u0 (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_pc(lk_pc),
        .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_target(rs_target), .rs_pred_taken(rs_pred_taken),
        .rs_pred_target(rs_pred_target),
        .flush(flush), .flush_pc(flush_pc)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        rv;
        logic [31:0] rpc;
        logic        rt;
        logic [31:0] rtgt;
        logic        pt;
        logic [31:0] ptgt;
        logic        eflush;
        logic [31:0] epc;
        logic [31:0] lpc;
        logic        ehit;
        logic        etaken;
        logic [31:0] etgt;
    } vec_t;

    localparam logic [31:0] PA = 32'h1014, PB = 32'h1114, PC = 32'h1214,
                            PD = 32'h1314, PE = 32'h1414;
    localparam int NV = 22;

    // Set 5 carries every tag below. Counter value per row in comments.
    localparam vec_t VEC [NV] = '{
        '{8'd4, 1'b1, PA, 1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 32'h0,    PA, 1'b0, 1'b0, 32'h0},    // R4 nt miss: no entry
        '{8'd4, 1'b1, PA, 1'b1, 32'h2000, 1'b0, 32'h0,    1'b1, 32'h2000, PA, 1'b1, 1'b1, 32'h2000}, // R4 alloc ctr3
        '{8'd5, 1'b1, PA, 1'b0, 32'h0,    1'b1, 32'h2000, 1'b1, 32'h1018, PA, 1'b1, 1'b1, 32'h2000}, // R5 ctr2
        '{8'd5, 1'b1, PA, 1'b0, 32'h0,    1'b1, 32'h2000, 1'b1, 32'h1018, PA, 1'b1, 1'b0, 32'h2000}, // R5 ctr1
        '{8'd5, 1'b1, PA, 1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 32'h0,    PA, 1'b1, 1'b0, 32'h2000}, // R5 ctr0
        '{8'd5, 1'b1, PA, 1'b0, 32'h0,    1'b0, 32'h0,    1'b0, 32'h0,    PA, 1'b1, 1'b0, 32'h2000}, // R5 floor
        '{8'd5, 1'b1, PA, 1'b1, 32'h2000, 1'b0, 32'h0,    1'b1, 32'h2000, PA, 1'b1, 1'b0, 32'h2000}, // R5 ctr1
        '{8'd5, 1'b1, PA, 1'b1, 32'h3000, 1'b0, 32'h0,    1'b1, 32'h3000, PA, 1'b1, 1'b1, 32'h3000}, // R5 ctr2 new tgt
        '{8'd6, 1'b1, PA, 1'b1, 32'h3000, 1'b1, 32'h3000, 1'b0, 32'h0,    PA, 1'b1, 1'b1, 32'h3000}, // R6 correct
        '{8'd5, 1'b1, PA, 1'b1, 32'h3000, 1'b1, 32'h3000, 1'b0, 32'h0,    PA, 1'b1, 1'b1, 32'h3000}, // R5 ceiling
        '{8'd6, 1'b1, PA, 1'b1, 32'h4000, 1'b1, 32'h3000, 1'b1, 32'h4000, PA, 1'b1, 1'b1, 32'h4000}, // R6 wrong tgt
        '{8'd1, 1'b1, PB, 1'b1, 32'h6100, 1'b0, 32'h0,    1'b1, 32'h6100, PB, 1'b1, 1'b1, 32'h6100}, // R1 way1
        '{8'd1, 1'b1, PC, 1'b1, 32'h6200, 1'b0, 32'h0,    1'b1, 32'h6200, PC, 1'b1, 1'b1, 32'h6200}, // R1 way2
        '{8'd1, 1'b1, PD, 1'b1, 32'h6300, 1'b0, 32'h0,    1'b1, 32'h6300, PD, 1'b1, 1'b1, 32'h6300}, // R1 way3
        '{8'd1, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0,    1'b0, 32'h0,    PA, 1'b1, 1'b1, 32'h4000}, // R1 A kept
        '{8'd7, 1'b1, PA, 1'b1, 32'h4000, 1'b1, 32'h4000, 1'b0, 32'h0,    PA, 1'b1, 1'b1, 32'h4000}, // R7 touch way0
        '{8'd7, 1'b1, PE, 1'b1, 32'h5000, 1'b0, 32'h0,    1'b1, 32'h5000, PC, 1'b0, 1'b0, 32'h0},    // R7 C evicted
        '{8'd7, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0,    1'b0, 32'h0,    PE, 1'b1, 1'b1, 32'h5000}, // R7 E present
        '{8'd7, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0,    1'b0, 32'h0,    PB, 1'b1, 1'b1, 32'h6100}, // R7 B kept
        '{8'd7, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0,    1'b0, 32'h0,    PD, 1'b1, 1'b1, 32'h6300}, // R7 D kept
        '{8'd3, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0,    1'b0, 32'h0,    32'h1018, 1'b0, 1'b0, 32'h0}, // R3 other set
        '{8'd3, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0,    1'b0, 32'h0,    32'h2014, 1'b0, 1'b0, 32'h0}   // R3 unknown tag
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_rs();
        rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; rs_target = '0;
        rs_pred_taken = 1'b0; rs_pred_target = '0;
    endtask

    task automatic look(input logic [31:0] pc, input bit eh, input bit et,
                        input logic [31:0] etg, input string req);
        lk_req = 1'b1; lk_pc = pc;
        #0.5;
        chk(lk_hit == eh, req, "lk_hit", {31'd0, lk_hit}, {31'd0, eh});
        chk(lk_taken == et, req, "lk_taken", {31'd0, lk_taken}, {31'd0, et});
        chk(lk_target == etg, req, "lk_target", lk_target, etg);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lk_req = 1'b0; lk_pc = '0; idle_rs();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R9 reset state
        chk(flush == 1'b0, "R9", "flush after reset", {31'd0, flush}, 32'd0);
        look(PA, 1'b0, 1'b0, 32'h0, "R9");

        // table walk
        for (int i = 0; i < NV; i++) begin
            string rq;
            @(negedge clk);
            rq = $sformatf("R%0d row%0d", VEC[i].req, i);
            lk_req = 1'b0;
            rs_valid = VEC[i].rv; rs_pc = VEC[i].rpc; rs_taken = VEC[i].rt;
            rs_target = VEC[i].rtgt; rs_pred_taken = VEC[i].pt;
            rs_pred_target = VEC[i].ptgt;
            @(posedge clk); #0.5;
            idle_rs();
            chk(flush == VEC[i].eflush, rq, "flush", {31'd0, flush}, {31'd0, VEC[i].eflush});
            if (VEC[i].eflush)
                chk(flush_pc == VEC[i].epc, rq, "flush_pc", flush_pc, VEC[i].epc);
            look(VEC[i].lpc, VEC[i].ehit, VEC[i].etaken, VEC[i].etgt, rq);
        end

        // R3 lookup not requested on a held entry
        @(negedge clk);
        lk_req = 1'b0; lk_pc = PA; #0.5;
        chk(lk_hit == 1'b0 && lk_target == 32'h0, "R3", "lk_req low",
            lk_target, 32'h0);

        // R8 lookup and update of the same entry in one cycle
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = PA; rs_taken = 1'b1; rs_target = 32'h7000;
        rs_pred_taken = 1'b1; rs_pred_target = 32'h4000;
        look(PA, 1'b1, 1'b1, 32'h4000, "R8 before edge");
        @(posedge clk); #0.5;
        idle_rs();
        chk(flush == 1'b1, "R8", "flush", {31'd0, flush}, 32'd1);
        chk(flush_pc == 32'h7000, "R8", "flush_pc", flush_pc, 32'h7000);
        look(PA, 1'b1, 1'b1, 32'h7000, "R8 after edge");
        @(posedge clk); #0.5;
        chk(flush == 1'b0, "R6", "flush one cycle", {31'd0, flush}, 32'd0);

        // R9 reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(flush == 1'b0, "R9", "flush cleared", {31'd0, flush}, 32'd0);
        look(PA, 1'b0, 1'b0, 32'h0, "R9 A gone");
        look(PE, 1'b0, 1'b0, 32'h0, "R9 E gone");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule